// File: doc/BRIEF.md
# Slotted Codec Word Buffer Controller

This block manages a small bank of transmit and receive holding registers for a time-slotted serial codec port. It sits between a CPU register port and a per-slot serial shifter. The serial side is reduced to one word strobe per active slot. Each strobe carries one received word in and presents one transmit word out. A slot index counts the strobes since the last wrap. When the index reaches the programmed length, the block wraps the index to zero and performs a bulk exchange in both directions. The received shadow words move into the receive buffers, and the transmit buffers move into the transmit shadow words. A one-cycle interrupt pulse marks each wrap.

Buffer location `i` serves the `i`-th strobe after a wrap, whatever slot of the frame that strobe belongs to. Four sticky status flags tell software when to refill or drain the buffers:

- transmit buffers empty
- transmit underflow
- receive buffers full
- receive overflow

Each flag considers only the locations that the current length puts in use. A transmit location that was not rewritten before an exchange sends its old word again.

Top module: `slotbuf_ctrl`

## Requirements
- R1: `slot_idx` increments on each `slot_stb`. On a strobe seen while `slot_idx` equals `cfg_len`, it returns to 0. A length value L therefore gives L+1 words per exchange.
- R2: `irq` is high for exactly the one cycle after each strobe that wraps the index, and low otherwise.
- R3: After an exchange, a read of address i returns the word received on the i-th strobe of that period (i counted from 0). `cpu_rdata` is valid in the cycle after `cpu_rd` and holds its value when there is no read.
- R4: On each strobe with index k, `ser_tx_data` updates in the next cycle to the word that the CPU wrote to location k before the last exchange.
- R5: A transmit location in use that was not written since the previous exchange sends its previous word again, and `st_tx_unf` rises at that exchange.
- R6: `st_tx_empty` is set by each exchange and cleared by a CPU write to any transmit location.
- R7: `st_tx_unf` stays set until every underflowed in-use location has been written. A write to a different location does not clear it.
- R8: `st_rx_full` is set by each exchange and clears only after every in-use receive location has been read.
- R9: An exchange that overwrites an unread in-use receive location sets `st_rx_ovf`; the old word is lost. Reading that location clears the flag.
- R10: Locations with an index greater than `cfg_len` have no effect on any of the four status flags.
- R11: A synchronous reset sets the index, the interrupt, all buffers and all flags to 0, except `st_tx_empty`, which it sets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | LEN_W | Words per exchange, minus one |
| slot_stb | input | 1 | One active slot word boundary |
| ser_rx_data | input | DATA_W | Word received in the current slot |
| ser_tx_data | output | DATA_W | Word to transmit in the current slot |
| slot_idx | output | LEN_W | Buffer index of the next strobe |
| irq | output | 1 | One-cycle pulse after each exchange |
| cpu_wr | input | 1 | Transmit buffer write strobe |
| cpu_waddr | input | LEN_W | Transmit buffer write address |
| cpu_wdata | input | DATA_W | Transmit buffer write data |
| cpu_rd | input | 1 | Receive buffer read strobe |
| cpu_raddr | input | LEN_W | Receive buffer read address |
| cpu_rdata | output | DATA_W | Receive buffer read data, one cycle latency |
| st_tx_empty | output | 1 | Transmit buffers drained into shadow |
| st_tx_unf | output | 1 | Some in-use transmit location underflowed |
| st_rx_full | output | 1 | Unread data present in receive buffers |
| st_rx_ovf | output | 1 | Some in-use receive location was overwritten unread |

## Verification
The hardest state to reach is a mix of per-location flags where some locations have underflowed or overflowed and others have not. The aggregate flag must then follow exactly the locations still pending. The stimulus gets there by sweeping every length. In each period it skips a different, arithmetically chosen subset of writes and reads, so partial clears of both sticky flags occur across several periods. A directed run at a short length also leaves the out-of-range locations untouched, which shows that they never raise a flag.

// File: rtl/slotbuf_pkg.sv
package slotbuf_pkg;
  parameter int DEF_DATA_W = 16;
  parameter int DEF_LEN_W  = 2;
endpackage

// File: rtl/slotbuf_counter.sv
module slotbuf_counter #(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             irq_o
);
  assign wrap_o = stb && (cnt_o == len);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= wrap_o;
      if (stb) begin
        if (cnt_o == len) cnt_o <= '0;
        else              cnt_o <= cnt_o + 1'b1;
      end
    end
  end

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst) (stb && cnt_o == len) |=> cnt_o == '0); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst) (stb && cnt_o != len) |=> cnt_o == LEN_W'($past(cnt_o) + 1'b1)); // R1
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst) !stb |=> $stable(cnt_o)); // R1
  AST_IRQ_FROM_STB: assert property (@(posedge clk) disable iff (rst) irq_o |-> $past(stb)); // R2
endmodule

// File: rtl/slotbuf_txbank.sv
module slotbuf_txbank #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 2,
  localparam int NBUF  = 1 << LEN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              xfer,
  input  logic [LEN_W-1:0]  cnt,
  input  logic [NBUF-1:0]   inuse,
  input  logic              wr,
  input  logic [LEN_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              empty_o,
  output logic              unf_o
);
  logic [DATA_W-1:0] buf_q [NBUF];
  logic [DATA_W-1:0] shd_q [NBUF];
  logic [NBUF-1:0]   written_q, written_n;
  logic [NBUF-1:0]   unf_q, unf_n;
  logic [NBUF-1:0]   wr_hit;

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      wr_hit[i]    = wr && (waddr == LEN_W'(i));
      written_n[i] = wr_hit[i] ? 1'b1 : (xfer ? 1'b0 : written_q[i]);
      unf_n[i]     = wr_hit[i] ? 1'b0 :
                     ((xfer && inuse[i] && !written_q[i]) ? 1'b1 : unf_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (wr) buf_q[waddr] <= wdata;
    if (xfer) begin
      for (int i = 0; i < NBUF; i++) shd_q[i] <= buf_q[i];
    end
    if (rst) begin
      for (int i = 0; i < NBUF; i++) begin
        buf_q[i] <= '0;
        shd_q[i] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data_o <= '0;
      written_q <= '0;
      unf_q     <= '0;
      empty_o   <= 1'b1;
      unf_o     <= 1'b0;
    end else begin
      if (stb) tx_data_o <= shd_q[cnt];
      written_q <= written_n;
      unf_q     <= unf_n;
      empty_o   <= wr ? 1'b0 : (xfer ? 1'b1 : empty_o);
      unf_o     <= |(unf_n & inuse);
    end
  end

  AST_EMPTY_CLEARED: assert property (@(posedge clk) disable iff (rst) wr |=> !empty_o); // R6
  AST_EMPTY_SET: assert property (@(posedge clk) disable iff (rst) (xfer && !wr) |=> empty_o); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst) !stb |=> $stable(tx_data_o)); // R4

  for (genvar g = 0; g < NBUF; g++) begin : g_unf_chk
    AST_UNF_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
      $fell(unf_q[g]) |-> $past(wr && waddr == LEN_W'(g))); // R7
  end
endmodule

// File: rtl/slotbuf_rxbank.sv
module slotbuf_rxbank #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 2,
  localparam int NBUF  = 1 << LEN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              xfer,
  input  logic [LEN_W-1:0]  cnt,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [NBUF-1:0]   inuse,
  input  logic              rd,
  input  logic [LEN_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] shd_q [NBUF];
  logic [DATA_W-1:0] buf_q [NBUF];
  logic [NBUF-1:0]   unread_q, unread_n;
  logic [NBUF-1:0]   ovf_q, ovf_n;
  logic [NBUF-1:0]   rd_hit;

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      rd_hit[i]   = rd && (raddr == LEN_W'(i));
      unread_n[i] = (xfer && inuse[i]) ? 1'b1 : (rd_hit[i] ? 1'b0 : unread_q[i]);
      ovf_n[i]    = (xfer && inuse[i] && unread_q[i] && !rd_hit[i]) ||
                    (ovf_q[i] && !rd_hit[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (stb) shd_q[cnt] <= rx_data;
    if (xfer) begin
      for (int i = 0; i < NBUF; i++)
        buf_q[i] <= (LEN_W'(i) == cnt) ? rx_data : shd_q[i];
    end
    if (rst) begin
      for (int i = 0; i < NBUF; i++) begin
        shd_q[i] <= '0;
        buf_q[i] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      unread_q <= '0;
      ovf_q    <= '0;
      full_o   <= 1'b0;
      ovf_o    <= 1'b0;
    end else begin
      if (rd) rdata_o <= buf_q[raddr];
      unread_q <= unread_n;
      ovf_q    <= ovf_n;
      full_o   <= |(unread_n & inuse);
      ovf_o    <= |(ovf_n & inuse);
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst) !rd |=> $stable(rdata_o)); // R3
  AST_FULL_AFTER_XFER: assert property (@(posedge clk) disable iff (rst) xfer |=> full_o); // R8
  AST_OVF_RISE_AT_XFER: assert property (@(posedge clk) disable iff (rst)
    ((ovf_q & ~$past(ovf_q)) != '0) |-> $past(xfer)); // R9
endmodule

// File: rtl/slotbuf_ctrl.sv
module slotbuf_ctrl
  import slotbuf_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int LEN_W  = DEF_LEN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              slot_stb,
  input  logic [DATA_W-1:0] ser_rx_data,
  output logic [DATA_W-1:0] ser_tx_data,
  output logic [LEN_W-1:0]  slot_idx,
  output logic              irq,
  input  logic              cpu_wr,
  input  logic [LEN_W-1:0]  cpu_waddr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic [LEN_W-1:0]  cpu_raddr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              st_tx_empty,
  output logic              st_tx_unf,
  output logic              st_rx_full,
  output logic              st_rx_ovf
);
  localparam int NBUF = 1 << LEN_W;

  logic            wrap;
  logic [NBUF-1:0] inuse;

  for (genvar g = 0; g < NBUF; g++) begin : g_inuse
    assign inuse[g] = (LEN_W'(g) <= cfg_len);
  end

  slotbuf_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .stb(slot_stb), .len(cfg_len),
    .cnt_o(slot_idx), .wrap_o(wrap), .irq_o(irq)
  );

  slotbuf_txbank #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst(rst), .stb(slot_stb), .xfer(wrap), .cnt(slot_idx),
    .inuse(inuse), .wr(cpu_wr), .waddr(cpu_waddr), .wdata(cpu_wdata),
    .tx_data_o(ser_tx_data), .empty_o(st_tx_empty), .unf_o(st_tx_unf)
  );

  slotbuf_rxbank #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst(rst), .stb(slot_stb), .xfer(wrap), .cnt(slot_idx),
    .rx_data(ser_rx_data), .inuse(inuse), .rd(cpu_rd), .raddr(cpu_raddr),
    .rdata_o(cpu_rdata), .full_o(st_rx_full), .ovf_o(st_rx_ovf)
  );

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (st_tx_empty && !st_tx_unf && !st_rx_full && !st_rx_ovf && !irq)); // R11
endmodule

// File: tb/slotbuf_ctrl_tb.sv
module slotbuf_ctrl_tb;
  localparam int DW = 16;
  localparam int LW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] cfg_len = '0;
  logic          slot_stb = 1'b0;
  logic [DW-1:0] ser_rx_data = '0;
  logic [DW-1:0] ser_tx_data;
  logic [LW-1:0] slot_idx;
  logic          irq;
  logic          cpu_wr = 1'b0;
  logic [LW-1:0] cpu_waddr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_rd = 1'b0;
  logic [LW-1:0] cpu_raddr = '0;
  logic [DW-1:0] cpu_rdata;
  logic st_tx_empty, st_tx_unf, st_rx_full, st_rx_ovf;

  always #4 clk = ~clk;

  slotbuf_ctrl #(.DATA_W(DW), .LEN_W(LW)) u_dut (.*);

  int n_chk = 0;
  int n_fail = 0;

  // bench model, built from the requirements
  logic [DW-1:0] m_txbuf[4], m_txsh[4], m_rxsh[4], m_rxbuf[4];
  logic [3:0] m_wr, m_unf, m_unread, m_ovf, m_stale;
  logic       m_empty;
  int         m_cnt;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] mask();
    logic [3:0] m;
    for (int i = 0; i < 4; i++) m[i] = (i <= int'(cfg_len));
    return m;
  endfunction

  task automatic check_flags();
    chk("R6 tx_empty", {31'd0, st_tx_empty}, {31'd0, m_empty});
    chk("R7 tx_unf",   {31'd0, st_tx_unf},   {31'd0, |(m_unf & mask())});
    chk("R8 rx_full",  {31'd0, st_rx_full},  {31'd0, |(m_unread & mask())});
    chk("R9 rx_ovf",   {31'd0, st_rx_ovf},   {31'd0, |(m_ovf & mask())});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      m_txbuf[i] = '0; m_txsh[i] = '0; m_rxsh[i] = '0; m_rxbuf[i] = '0;
    end
    m_wr = '0; m_unf = '0; m_unread = '0; m_ovf = '0; m_stale = '0;
    m_empty = 1'b1; m_cnt = 0;
    chk("R11 slot_idx", {30'd0, slot_idx}, 32'd0);
    chk("R11 irq", {31'd0, irq}, 32'd0);
    chk("R11 tx_data", {16'd0, ser_tx_data}, 32'd0);
    check_flags();
  endtask

  task automatic cpu_write(input int a, input logic [DW-1:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_waddr = LW'(a); cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
    m_txbuf[a] = d; m_wr[a] = 1'b1; m_unf[a] = 1'b0; m_empty = 1'b0;
    check_flags();
  endtask

  task automatic cpu_read(input int a);
    @(negedge clk); cpu_rd = 1'b1; cpu_raddr = LW'(a);
    @(negedge clk); cpu_rd = 1'b0;
    chk("R3 rdata", {16'd0, cpu_rdata}, {16'd0, m_rxbuf[a]});
    m_unread[a] = 1'b0; m_ovf[a] = 1'b0;
    check_flags();
  endtask

  task automatic strobe(input logic [DW-1:0] rx);
    int  k;
    logic wrap;
    k = m_cnt;
    wrap = (k == int'(cfg_len));
    @(negedge clk); slot_stb = 1'b1; ser_rx_data = rx;
    @(negedge clk); slot_stb = 1'b0;
    if (m_stale[k]) chk("R5 repeat tx", {16'd0, ser_tx_data}, {16'd0, m_txsh[k]});
    else            chk("R4 tx word", {16'd0, ser_tx_data}, {16'd0, m_txsh[k]});
    chk("R2 irq", {31'd0, irq}, {31'd0, wrap});
    m_rxsh[k] = rx;
    if (wrap) begin
      for (int i = 0; i < 4; i++) begin
        m_rxbuf[i] = m_rxsh[i];
        m_stale[i] = !m_wr[i];
        if (i <= k) begin
          if (m_unread[i]) m_ovf[i] = 1'b1;
          m_unread[i] = 1'b1;
          if (!m_wr[i]) m_unf[i] = 1'b1;
        end
        m_txsh[i] = m_txbuf[i];
      end
      m_wr = '0; m_empty = 1'b1; m_cnt = 0;
    end else m_cnt = k + 1;
    chk("R1 slot_idx", {30'd0, slot_idx}, m_cnt);
    check_flags();
    if (wrap) begin
      @(negedge clk);
      chk("R2 irq one cycle", {31'd0, irq}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // sweep every length with rotating partial write and read patterns
    for (int len = 0; len < 4; len++) begin
      cfg_len = LW'(len);
      do_reset();
      for (int p = 0; p < 7; p++) begin
        for (int i = 0; i <= len; i++)
          if (((p * 3 + i) % 4) != 1 || p == 6) cpu_read(i);
        for (int i = 0; i <= len; i++)
          if (((p + i) % 3) != 0 || p == 5) cpu_write(i, DW'(16'h1000 * len + 16'h100 * p + i + 1));
        for (int i = 0; i <= len; i++)
          strobe(DW'(16'hA000 + 16'h100 * len + 16'h10 * p + i));
      end
    end
    // R10: locations past the length never raise a flag
    cfg_len = 2'd1;
    do_reset();
    cpu_write(0, 16'h0B0B);
    cpu_write(1, 16'h0B1B);
    strobe(16'h5A00);
    strobe(16'h5A01);
    chk("R10 unused tx locations", {31'd0, st_tx_unf}, 32'd0);
    cpu_read(0);
    cpu_read(1);
    chk("R10 unused rx locations", {31'd0, st_rx_full}, 32'd0);
    strobe(16'h5A02);
    strobe(16'h5A03);
    chk("R10 no overflow from unused", {31'd0, st_rx_ovf}, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule